// File: doc/BRIEF.md
# Dual-Count Pulse-Width Modulation Generator

This block produces a single pulse-width modulated output from one fast clock. The active part and the inactive part of each period are programmed separately by two 16-bit counts. Each count is used plus one. A 4-bit prescaler stretches every count step to (ps+1) input ticks. An input tick is either every fast clock cycle or a single-cycle slow-tick enable pulse supplied from outside, chosen by a source-select bit. The active output level follows a polarity bit.

Software programs the block through a small write port. Address 0 holds the control word, address 1 holds the active count and address 2 holds the inactive count. New counts wait in holding registers and reach the working counts only at a period boundary, so a period is never torn. A prescale change acts on the very next tick. If a count is zero, the output is held static.

The controller is a five-state machine. ST_IDLE is disabled. ST_ACTIVE and ST_INACTIVE are the two counting phases. ST_STUCK_HI holds the output at the active level and ST_STUCK_LO holds it at the inactive level. The named transitions are:
- T_START: ST_IDLE to a phase chosen from the holding counts, when enable is seen.
- T_STOP: any state to ST_IDLE, when enable is clear.
- T_FLIP: ST_ACTIVE to ST_INACTIVE, on the last active step.
- T_WRAP: ST_INACTIVE to a phase chosen from the holding counts, on the last inactive step. This is where the working counts reload.
- T_RECHECK: ST_STUCK_HI or ST_STUCK_LO to a phase chosen from the holding counts, on every step.

Top module: `pwm_dual_count`

## Requirements
- R1: After reset the output is 0, polarity is normal and the generator is disabled.
- R2: With the fast source, the active phase lasts (ps+1)*(on+1) clock cycles and the inactive phase lasts (ps+1)*(off+1) clock cycles, when both counts are nonzero.
- R3: When control bit 2 is 1, only cycles with slow_tick high count as ticks. Each phase then lasts (ps+1)*(count+1) slow ticks.
- R4: When control bit 1 is 1, the active level is 0 and the inactive level is 1. When it is 0, the active level is 1.
- R5: If the active count is nonzero and the inactive count is zero, the output is held at the active level.
- R6: If the active count is zero, the output is held at the inactive level, whatever the inactive count is.
- R7: A count write goes to a holding register. It is used only from the next T_WRAP (or T_RECHECK) onwards. A write landing on the same clock edge as that reload takes effect at the following reload.
- R8: A write to the prescale field (control bits 7:4) acts on the next tick. A tick on which the prescaler's accumulated count already reaches or exceeds the new value ends the step at once.
- R9: When control bit 0 clears, the output shows the inactive level from the second cycle after the write. When it sets, the first phase is the active phase and starts in the second cycle after the write.
- R10: Writes use address 0 for control, 1 for the active count and 2 for the inactive count. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Single-cycle slow tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The interesting coincidence is a count write on the same edge as the inactive phase ending. On that edge the reload must take the old holding value while the holding register takes the new one. A prescale write landing in the middle of a step is a second such case. The bench provokes both by sweeping the write offset from each rising output edge across a full period. A behavioural reference model, updated on every edge, is compared with the output on every cycle. Directed run-length measurements then confirm the buffered and immediate behaviours in absolute cycles.

// File: rtl/pwm_dc_pkg.sv
package pwm_dc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACTIVE   = 3'd1,
        ST_INACTIVE = 3'd2,
        ST_STUCK_HI = 3'd3,
        ST_STUCK_LO = 3'd4
    } pwm_state_e;

    // register addresses
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_ON   = 1;
    localparam int ADDR_OFF  = 2;

    // control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_INV_BIT  = 1;
    localparam int CTRL_SLOW_BIT = 2;
    localparam int CTRL_PS_LSB   = 4;

endpackage

// File: rtl/pwm_dc_prescaler.sv
module pwm_dc_prescaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            sel_slow,
    input  logic            slow_tick,
    input  logic [PS_W-1:0] ps,
    output logic            step
);

    logic            tick;
    logic [PS_W-1:0] acc_q;

    always_comb begin
        tick = sel_slow ? slow_tick : 1'b1;
        // comparison instead of equality so a lowered prescale ends the step now
        step = tick && (acc_q >= ps);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!run) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= acc_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_dc_regs.sv
module pwm_dc_regs
    import pwm_dc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cfg_en,
    output logic              cfg_inv,
    output logic              cfg_slow,
    output logic [PS_W-1:0]   cfg_ps,
    output logic [CNT_W-1:0]  hold_on,
    output logic [CNT_W-1:0]  hold_off
);

    localparam int PS_MSB = CTRL_PS_LSB + PS_W - 1;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DATA_W-1:PS_MSB+1], wr_data[3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_inv  <= 1'b0;
            cfg_slow <= 1'b0;
            cfg_ps   <= '0;
            hold_on  <= '0;
            hold_off <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADDR_CTRL): begin
                    cfg_en   <= wr_data[CTRL_EN_BIT];
                    cfg_inv  <= wr_data[CTRL_INV_BIT];
                    cfg_slow <= wr_data[CTRL_SLOW_BIT];
                    cfg_ps   <= wr_data[PS_MSB:CTRL_PS_LSB];
                end
                ADDR_W'(ADDR_ON):  hold_on  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADDR_OFF): hold_off <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwm_dc_fsm.sv
module pwm_dc_fsm
    import pwm_dc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_inv,
    input  logic             step,
    input  logic [CNT_W-1:0] hold_on,
    input  logic [CNT_W-1:0] hold_off,
    output logic             run,
    output logic             pwm_out
);

    pwm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] won_q, won_d;
    logic [CNT_W-1:0] woff_q, woff_d;
    logic             active;

    function automatic pwm_state_e pick_phase(input logic [CNT_W-1:0] on_c,
                                              input logic [CNT_W-1:0] off_c);
        if (on_c == '0)       return ST_STUCK_LO;
        else if (off_c == '0) return ST_STUCK_HI;
        else                  return ST_ACTIVE;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            won_q   <= '0;
            woff_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            won_q   <= won_d;
            woff_q  <= woff_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        won_d   = won_q;
        woff_d  = woff_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_en) begin                 // T_START
                    won_d   = hold_on;
                    woff_d  = hold_off;
                    state_d = pick_phase(hold_on, hold_off);
                    cnt_d   = '0;
                end
            end
            ST_ACTIVE: begin
                if (!cfg_en) begin                // T_STOP
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (step) begin
                    if (cnt_q == won_q) begin     // T_FLIP
                        state_d = ST_INACTIVE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_INACTIVE: begin
                if (!cfg_en) begin                // T_STOP
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (step) begin
                    if (cnt_q == woff_q) begin    // T_WRAP
                        won_d   = hold_on;
                        woff_d  = hold_off;
                        state_d = pick_phase(hold_on, hold_off);
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_STUCK_HI, ST_STUCK_LO: begin
                if (!cfg_en) begin                // T_STOP
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (step) begin          // T_RECHECK
                    won_d   = hold_on;
                    woff_d  = hold_off;
                    state_d = pick_phase(hold_on, hold_off);
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        active  = (state_q == ST_ACTIVE) || (state_q == ST_STUCK_HI);
        run     = (state_q != ST_IDLE);
        pwm_out = active ^ cfg_inv;
    end

endmodule

// File: rtl/pwm_dual_count.sv
module pwm_dual_count #(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);

    logic             cfg_en;
    logic             cfg_inv;
    logic             cfg_slow;
    logic [PS_W-1:0]  cfg_ps;
    logic [CNT_W-1:0] hold_on;
    logic [CNT_W-1:0] hold_off;
    logic             run;
    logic             step;

    pwm_dc_regs #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_en  (cfg_en),
        .cfg_inv (cfg_inv),
        .cfg_slow(cfg_slow),
        .cfg_ps  (cfg_ps),
        .hold_on (hold_on),
        .hold_off(hold_off)
    );

    pwm_dc_prescaler #(
        .PS_W(PS_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sel_slow (cfg_slow),
        .slow_tick(slow_tick),
        .ps       (cfg_ps),
        .step     (step)
    );

    pwm_dc_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_inv (cfg_inv),
        .step    (step),
        .hold_on (hold_on),
        .hold_off(hold_off),
        .run     (run),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_dc_sva.sv
module pwm_dc_sva #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_tick,
    input logic             cfg_en,
    input logic             cfg_inv,
    input logic             cfg_slow,
    input logic [PS_W-1:0]  cfg_ps,
    input logic [CNT_W-1:0] hold_on,
    input logic [CNT_W-1:0] hold_off,
    input logic             run,
    input logic             step,
    input logic             pwm_out
);

    AST_DISABLED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (pwm_out == cfg_inv)); // R9

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && ($past(hold_on) != '0) && ($past(hold_off) != '0))
            |-> (pwm_out != cfg_inv)); // R9

    AST_SLOW_GATES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slow && !slow_tick) |-> !step); // R3

    AST_FAST_PS0_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_slow && (cfg_ps == '0)) |-> step); // R8

    AST_OUT_MOVES_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(cfg_en) && !$past(step) && $stable(cfg_inv))
            |-> $stable(pwm_out)); // R2

endmodule

bind pwm_dual_count pwm_dc_sva #(
    .CNT_W(CNT_W),
    .PS_W (PS_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .cfg_en   (cfg_en),
    .cfg_inv  (cfg_inv),
    .cfg_slow (cfg_slow),
    .cfg_ps   (cfg_ps),
    .hold_on  (hold_on),
    .hold_off (hold_off),
    .run      (run),
    .step     (step),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_dual_count_tb.sv
module pwm_dual_count_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        slow_tick;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        pwm_out;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    bit    slow_run = 1'b0;
    int    sdiv = 0;

    // reference model state
    int m_en, m_inv, m_sel, m_ps, m_hon, m_hoff, m_won, m_woff;
    int m_phase, m_pre, m_cnt;   // phase: 0 idle, 1 act, 2 inact, 3 stuck hi, 4 stuck lo

    pwm_dual_count u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_tick(slow_tick),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int m_pick(input int on_c, input int off_c);
        if (on_c == 0)  return 4;
        if (off_c == 0) return 3;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_inv = 0; m_sel = 0; m_ps = 0; m_hon = 0; m_hoff = 0;
            m_won = 0; m_woff = 0; m_phase = 0; m_pre = 0; m_cnt = 0;
        end else begin
            bit tk, st, was_run;
            tk = (m_sel != 0) ? slow_tick : 1'b1;
            st = tk && (m_pre >= m_ps);
            was_run = (m_phase != 0);
            if (m_phase == 0) begin
                if (m_en != 0) begin
                    m_won = m_hon; m_woff = m_hoff;
                    m_phase = m_pick(m_hon, m_hoff); m_cnt = 0;
                end
            end else if (m_en == 0) begin
                m_phase = 0; m_cnt = 0;
            end else if (st) begin
                if (m_phase == 1) begin
                    if (m_cnt == m_won) begin m_phase = 2; m_cnt = 0; end
                    else m_cnt++;
                end else if (m_phase == 2 && m_cnt != m_woff) begin
                    m_cnt++;
                end else begin
                    m_won = m_hon; m_woff = m_hoff;
                    m_phase = m_pick(m_hon, m_hoff); m_cnt = 0;
                end
            end
            if (!was_run) m_pre = 0;
            else if (st) m_pre = 0;
            else if (tk) m_pre++;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_en = wr_data[0]; m_inv = wr_data[1];
                        m_sel = wr_data[2]; m_ps = int'(wr_data[7:4]);
                    end
                    2'd1: m_hon = int'(wr_data);
                    2'd2: m_hoff = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            logic exp;
            exp = ((m_phase == 1 || m_phase == 3) ? 1'b1 : 1'b0) ^ (m_inv != 0);
            checks++;
            if (pwm_out !== exp) begin
                failures++;
                $display("FAIL %s model compare at %0t: actual=%b expected=%b",
                         cur_req, $time, pwm_out, exp);
            end
        end
    end

    always @(negedge clk) begin
        if (slow_run) begin
            sdiv = (sdiv == 2) ? 0 : sdiv + 1;
            slow_tick = (sdiv == 0);
        end else begin
            sdiv = 0;
            slow_tick = 1'b0;
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl(input bit en, input bit inv, input bit slow,
                                         input int ps);
        return {8'h00, 4'(ps), 1'b0, slow, inv, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_len(input logic lvl, output int n);
        while (pwm_out == lvl) @(negedge clk);
        while (pwm_out != lvl) @(negedge clk);
        n = 0;
        while (pwm_out == lvl) begin n++; @(negedge clk); end
    endtask

    task automatic wait_rise();
        while (pwm_out == 1'b1) @(negedge clk);
        while (pwm_out == 1'b0) @(negedge clk);
    endtask

    task automatic count_rest(input logic lvl, output int n);
        n = 0;
        while (pwm_out == lvl) begin n++; @(negedge clk); end
    endtask

    task automatic hold_check(input string req, input logic lvl, input int cyc);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            if (pwm_out !== lvl) bad++;
            @(negedge clk);
        end
        check_int(req, bad, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; slow_tick = 1'b0;
        repeat (4) @(negedge clk);
        check_int("R1", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R1", int'(pwm_out), 0);

        // R10 register map, R2 phase lengths
        cur_req = "R10";
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd3);
        wr(2'd0, ctrl(1, 0, 0, 1));
        cur_req = "R2";
        run_len(1'b1, n); check_int("R2 active length", n, 6);
        run_len(1'b0, n); check_int("R2 inactive length", n, 8);

        cur_req = "R10";
        wr(2'd3, 16'hFFFF);
        run_len(1'b1, n); check_int("R10 addr3 ignored", n, 6);

        cur_req = "R4";
        wr(2'd0, ctrl(1, 1, 0, 1));
        run_len(1'b0, n); check_int("R4 active low length", n, 6);
        run_len(1'b1, n); check_int("R4 inactive high length", n, 8);
        wr(2'd0, ctrl(1, 0, 0, 1));

        // R7 buffering of count writes
        cur_req = "R7";
        wr(2'd0, ctrl(1, 0, 0, 0));
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd3);
        run_len(1'b1, n);
        run_len(1'b1, n); check_int("R7 settled active length", n, 4);
        wait_rise();
        wr(2'd1, 16'd9);
        count_rest(1'b1, n); check_int("R7 current phase unchanged", n, 2);
        run_len(1'b1, n); check_int("R7 new count after wrap", n, 10);

        // R8 immediate prescale
        cur_req = "R8";
        wr(2'd1, 16'd7);
        wr(2'd2, 16'd7);
        wr(2'd0, ctrl(1, 0, 0, 3));
        run_len(1'b1, n);
        run_len(1'b1, n); check_int("R8 slow prescale length", n, 32);
        wait_rise();
        wr(2'd0, ctrl(1, 0, 0, 0));
        count_rest(1'b1, n); check_int("R8 prescale mid-phase", n, 8);

        cur_req = "R5";
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd0);
        repeat (60) @(negedge clk);
        hold_check("R5 held active", 1'b1, 40);

        cur_req = "R6";
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd4);
        repeat (40) @(negedge clk);
        hold_check("R6 held inactive", 1'b0, 40);
        wr(2'd2, 16'd0);
        repeat (20) @(negedge clk);
        hold_check("R6 both zero inactive", 1'b0, 40);

        cur_req = "R3";
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd1);
        slow_run = 1'b1;
        wr(2'd0, ctrl(1, 0, 1, 0));
        run_len(1'b1, n);
        run_len(1'b1, n); check_int("R3 slow active length", n, 6);
        run_len(1'b0, n); check_int("R3 slow inactive length", n, 6);
        wr(2'd0, ctrl(1, 0, 1, 1));
        run_len(1'b1, n);
        run_len(1'b1, n); check_int("R3 slow with prescale", n, 12);
        wr(2'd0, ctrl(1, 0, 0, 0));
        slow_run = 1'b0;

        cur_req = "R9";
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd2);
        run_len(1'b1, n);
        wait_rise();
        wr(2'd0, ctrl(0, 0, 0, 0));
        @(negedge clk);
        check_int("R9 disabled inactive", int'(pwm_out), 0);
        wr(2'd0, ctrl(0, 1, 0, 0));
        @(negedge clk);
        check_int("R9 disabled inactive inverted", int'(pwm_out), 1);
        wr(2'd0, ctrl(1, 0, 0, 0));
        @(negedge clk);
        check_int("R9 enable starts active", int'(pwm_out), 1);

        // R7 coincidence sweep: writes at every offset across a period
        cur_req = "R7";
        for (int k = 0; k < 14; k++) begin
            wait_rise();
            repeat (k) @(negedge clk);
            wr(2'd1, 16'(1 + (k % 3)));
            wr(2'd2, 16'(1 + (k % 2)));
            if (k % 4 == 0) wr(2'd0, ctrl(1, 0, 0, k % 3));
        end
        repeat (30) @(negedge clk);
        finish_run();
    end

endmodule